// File: doc/BRIEF.md
# Power-Down Wake and Interrupt Controller

This block manages the low-power state of a dual-slot card interface and produces the active-low interrupt towards the host microcontroller. When software raises its power-down bit, the block turns off the crystal oscillator enable and freezes the current slot selection. A small set of external events brings the device back: a card being inserted or pulled from either slot, the host re-selecting the device through its active-low chip select, a change on the auxiliary interrupt pin, or software dropping the power-down bit while chip select is held low.

On a wake, the oscillator enable rises at once. The interrupt line stays released for a fixed restart interval while the oscillator settles. After that interval the block pulls the interrupt low to report that it is ready. Status flags for card-presence changes, the auxiliary pin and the two character events (transmit empty, receive full) are sticky and are cleared by read strobes. Two mask inputs keep the auxiliary flag and the character flags from driving the interrupt, but those flags still latch. The detection logic runs on an always-on reference clock, and external pins are resynchronised before use.

Top module: `pdw_wake_irq`

## Requirements
- R1: After reset, osc_en is 1, irq_n is 1, sel_lock is 0, and every bit of hsr_flags and chr_flags is 0.
- R2: While running, a 0-to-1 transition of pdwn_req drives osc_en to 0 and sel_lock to 1. While sel_lock is 1, sel_card keeps its value and sel_req is ignored. While running, sel_req loads sel_idx into sel_card.
- R3: In power-down, a change of card_det[i] wakes the device and sets hsr_flags[i] (bit i reports a presence change on slot i).
- R4: In power-down, a 1-to-0 transition of cs_n wakes the device. This wake sets no bit in hsr_flags or chr_flags, yet irq_n goes low once restart ends and returns high after an hsr_rd pulse.
- R5: In power-down, any change on aux_pin wakes the device and sets hsr_flags[NCARD] (bit 2 with two slots).
- R6: In power-down, pdwn_req at 0 wakes the device while cs_n is 0. With cs_n at 1 and no other event, the device stays down (osc_en stays 0).
- R7: irq_n is held at 1 while sel_lock is 1. irq_n first reads 0 exactly RESTART_CYC cycles after the first cycle in which osc_en reads 1 again.
- R8: With aux_mask at 1, an aux_pin change sets hsr_flags[NCARD] but leaves irq_n at 1. Clearing aux_mask while that flag is set drives irq_n to 0.
- R9: With chr_mask at 1, tbe_evt sets chr_flags[0] and rbf_evt sets chr_flags[1], and irq_n stays at 1. With chr_mask at 0, either flag drives irq_n to 0.
- R10: hsr_rd clears hsr_flags and the pending wake report but not chr_flags. chr_rd clears only chr_flags. A set event in the same cycle as its clear leaves the flag set.
- R11: While running, irq_n is 0 exactly when a card flag, an unmasked auxiliary flag, an unmasked character flag or a pending wake report is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdwn_req | input | 1 | Software power-down bit; entry on its rising edge |
| card_det | input | NCARD | Card presence detectors, asynchronous |
| cs_n | input | 1 | Active-low chip select from the host, asynchronous |
| aux_pin | input | 1 | Auxiliary interrupt pin, asynchronous |
| aux_mask | input | 1 | Keeps the auxiliary flag off the interrupt |
| chr_mask | input | 1 | Keeps the character flags off the interrupt |
| tbe_evt | input | 1 | One-cycle transmit-buffer-empty event |
| rbf_evt | input | 1 | One-cycle receive-buffer-full event |
| hsr_rd | input | 1 | Read strobe of the card/auxiliary status |
| chr_rd | input | 1 | Read strobe of the character status |
| sel_req | input | 1 | Request to change the selected slot |
| sel_idx | input | SELW | Slot index for sel_req |
| osc_en | output | 1 | Crystal oscillator enable |
| sel_lock | output | 1 | High while slot selection is frozen |
| sel_card | output | SELW | Currently selected slot |
| hsr_flags | output | NCARD+1 | Sticky flags: slot changes in bits 0..NCARD-1, auxiliary in bit NCARD |
| chr_flags | output | 2 | Sticky flags: bit 0 transmit empty, bit 1 receive full |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The assertions assume that card_det, aux_pin and cs_n hold their reset-time levels (cards absent, auxiliary low, chip select high inside the synchroniser) until the first edge detector has loaded. They also assume that tbe_evt and rbf_evt are single-cycle pulses from the same clock domain. The stimulus holds the cards absent through reset and moves the asynchronous pins only on the falling clock edge. It leaves several idle cycles after each pin change so that the two-stage synchroniser and the edge detector settle before any result is sampled. The read strobes are driven one cycle wide, in the same way a host register read would produce them.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    typedef enum logic [1:0] {
        PW_RUN     = 2'd0,
        PW_DOWN    = 2'd1,
        PW_RESTART = 2'd2
    } pw_state_e;

    localparam int CHR_TBE = 0;
    localparam int CHR_RBF = 1;
endpackage

// File: rtl/pdw_edge_sync.sv
// Two-stage synchroniser plus change detector. The top bit of the vector is
// the select line, whose level and falling edge are reported separately.
module pdw_edge_sync #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-2:0] chg,
    output logic         msb_lvl,
    output logic         msb_fall
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL, s3: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign chg      = st_q.s2[W-2:0] ^ st_q.s3[W-2:0];
    assign msb_lvl  = st_q.s2[W-1];
    assign msb_fall = st_q.s3[W-1] & ~st_q.s2[W-1];
endmodule

// File: rtl/pdw_wake_fsm.sv
module pdw_wake_fsm
    import pdw_pkg::*;
#(
    parameter int RESTART_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdwn_req,
    input  logic evt_wake,
    input  logic cs_lvl,
    input  logic cs_fall,
    output logic osc_en,
    output logic locked,
    output logic wake_done
);
    localparam int CW = $clog2(RESTART_CYC + 1);

    typedef struct packed {
        pw_state_e     state;
        logic          pd_prev;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pd_prev = pdwn_req;
        wake_done    = 1'b0;
        case (st_q.state)
            PW_RUN: begin
                if (pdwn_req && !st_q.pd_prev) begin
                    st_d.state = PW_DOWN;
                end
            end
            PW_DOWN: begin
                if (evt_wake || cs_fall || (!pdwn_req && !cs_lvl)) begin
                    st_d.state = PW_RESTART;
                    st_d.cnt   = CW'(RESTART_CYC - 1);
                end
            end
            PW_RESTART: begin
                if (st_q.cnt == '0) begin
                    st_d.state = PW_RUN;
                    wake_done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.state = PW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: PW_RUN, pd_prev: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign osc_en = (st_q.state != PW_DOWN);
    assign locked = (st_q.state != PW_RUN);
endmodule

// File: rtl/pdw_irq_flags.sv
module pdw_irq_flags
    import pdw_pkg::*;
#(
    parameter int NCARD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCARD-1:0] card_chg,
    input  logic             aux_chg,
    input  logic             tbe_evt,
    input  logic             rbf_evt,
    input  logic             hsr_rd,
    input  logic             chr_rd,
    input  logic             wake_done,
    input  logic             running,
    input  logic             aux_mask,
    input  logic             chr_mask,
    output logic [NCARD-1:0] card_flags,
    output logic             aux_flag,
    output logic [1:0]       chr_flags,
    output logic             wake_pend,
    output logic             irq_n
);
    typedef struct packed {
        logic [NCARD-1:0] card;
        logic             aux;
        logic [1:0]       chr;
        logic             wake;
    } flg_t;

    flg_t st_d, st_q;
    logic [1:0] chr_set;

    always_comb begin
        chr_set          = '0;
        chr_set[CHR_TBE] = tbe_evt;
        chr_set[CHR_RBF] = rbf_evt;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCARD; i++) begin
            st_d.card[i] = (st_q.card[i] & ~hsr_rd) | card_chg[i];
        end
        st_d.aux  = (st_q.aux & ~hsr_rd) | aux_chg;
        st_d.wake = (st_q.wake & ~hsr_rd) | wake_done;
        st_d.chr  = (st_q.chr & ~{2{chr_rd}}) | chr_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_flags = st_q.card;
    assign aux_flag   = st_q.aux;
    assign chr_flags  = st_q.chr;
    assign wake_pend  = st_q.wake;
    assign irq_n      = ~(running & ((|st_q.card)
                                   | (st_q.aux & ~aux_mask)
                                   | ((|st_q.chr) & ~chr_mask)
                                   | st_q.wake));
endmodule

// File: rtl/pdw_wake_irq.sv
module pdw_wake_irq
    import pdw_pkg::*;
#(
    parameter int NCARD       = 2,
    parameter int RESTART_CYC = 16,
    parameter int SELW        = (NCARD > 1) ? $clog2(NCARD) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdwn_req,
    input  logic [NCARD-1:0] card_det,
    input  logic             cs_n,
    input  logic             aux_pin,
    input  logic             aux_mask,
    input  logic             chr_mask,
    input  logic             tbe_evt,
    input  logic             rbf_evt,
    input  logic             hsr_rd,
    input  logic             chr_rd,
    input  logic             sel_req,
    input  logic [SELW-1:0]  sel_idx,
    output logic             osc_en,
    output logic             sel_lock,
    output logic [SELW-1:0]  sel_card,
    output logic [NCARD:0]   hsr_flags,
    output logic [1:0]       chr_flags,
    output logic             irq_n
);
    localparam int SW = NCARD + 2;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

    logic [SW-2:0]    pin_chg;
    logic             cs_lvl;
    logic             cs_fall;
    logic             wake_done;
    logic             wake_pend;
    logic [NCARD-1:0] card_flags;
    logic             aux_flag;

    pdw_edge_sync #(
        .W       (SW),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      ({cs_n, aux_pin, card_det}),
        .chg      (pin_chg),
        .msb_lvl  (cs_lvl),
        .msb_fall (cs_fall)
    );

    pdw_wake_fsm #(
        .RESTART_CYC (RESTART_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdwn_req  (pdwn_req),
        .evt_wake  (|pin_chg),
        .cs_lvl    (cs_lvl),
        .cs_fall   (cs_fall),
        .osc_en    (osc_en),
        .locked    (sel_lock),
        .wake_done (wake_done)
    );

    pdw_irq_flags #(
        .NCARD (NCARD)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_chg   (pin_chg[NCARD-1:0]),
        .aux_chg    (pin_chg[NCARD]),
        .tbe_evt    (tbe_evt),
        .rbf_evt    (rbf_evt),
        .hsr_rd     (hsr_rd),
        .chr_rd     (chr_rd),
        .wake_done  (wake_done),
        .running    (~sel_lock),
        .aux_mask   (aux_mask),
        .chr_mask   (chr_mask),
        .card_flags (card_flags),
        .aux_flag   (aux_flag),
        .chr_flags  (chr_flags),
        .wake_pend  (wake_pend),
        .irq_n      (irq_n)
    );

    assign hsr_flags = {aux_flag, card_flags};

    // Slot selection register, frozen while not running.
    typedef struct packed {
        logic [SELW-1:0] sel;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (sel_req && !sel_lock) begin
            sel_d.sel = sel_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_card = sel_q.sel;
endmodule

// File: rtl/pdw_wake_irq_chk.sv
module pdw_wake_irq_chk #(
    parameter int NCARD = 2,
    parameter int SELW  = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            osc_en,
    input logic            sel_lock,
    input logic [SELW-1:0] sel_card,
    input logic            irq_n,
    input logic            chr_rd,
    input logic            tbe_evt,
    input logic            rbf_evt,
    input logic [1:0]      chr_flags,
    input logic            chr_mask,
    input logic            aux_mask,
    input logic [NCARD:0]  hsr_flags,
    input logic            wake_pend
);
    // R7
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lock |-> irq_n);

    // R2
    osc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> sel_lock);

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lock |=> $stable(sel_card));

    // R10
    chr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_rd && !tbe_evt && !rbf_evt) |=> (chr_flags == 2'b00));

    // R9
    chr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_mask && aux_mask && hsr_flags[NCARD-1:0] == '0 && !wake_pend) |-> irq_n);

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (wake_pend || hsr_flags != '0 || chr_flags != 2'b00));
endmodule

bind pdw_wake_irq pdw_wake_irq_chk #(
    .NCARD (NCARD),
    .SELW  (SELW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en    (osc_en),
    .sel_lock  (sel_lock),
    .sel_card  (sel_card),
    .irq_n     (irq_n),
    .chr_rd    (chr_rd),
    .tbe_evt   (tbe_evt),
    .rbf_evt   (rbf_evt),
    .chr_flags (chr_flags),
    .chr_mask  (chr_mask),
    .aux_mask  (aux_mask),
    .hsr_flags (hsr_flags),
    .wake_pend (wake_pend)
);

// File: tb/pdw_wake_irq_bench.sv
`timescale 1ns/1ps
module pdw_wake_irq_bench;
    localparam int NCARD       = 2;
    localparam int RESTART_CYC = 16;
    localparam int SELW        = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pdwn_req = 1'b0;
    logic [NCARD-1:0] card_det = '0;
    logic             cs_n = 1'b0;
    logic             aux_pin = 1'b0;
    logic             aux_mask = 1'b0;
    logic             chr_mask = 1'b0;
    logic             tbe_evt = 1'b0;
    logic             rbf_evt = 1'b0;
    logic             hsr_rd = 1'b0;
    logic             chr_rd = 1'b0;
    logic             sel_req = 1'b0;
    logic [SELW-1:0]  sel_idx = '0;
    logic             osc_en;
    logic             sel_lock;
    logic [SELW-1:0]  sel_card;
    logic [NCARD:0]   hsr_flags;
    logic [1:0]       chr_flags;
    logic             irq_n;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pdw_wake_irq #(
        .NCARD       (NCARD),
        .RESTART_CYC (RESTART_CYC),
        .SELW        (SELW)
    ) u_pdw_wake_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdwn_req  (pdwn_req),
        .card_det  (card_det),
        .cs_n      (cs_n),
        .aux_pin   (aux_pin),
        .aux_mask  (aux_mask),
        .chr_mask  (chr_mask),
        .tbe_evt   (tbe_evt),
        .rbf_evt   (rbf_evt),
        .hsr_rd    (hsr_rd),
        .chr_rd    (chr_rd),
        .sel_req   (sel_req),
        .sel_idx   (sel_idx),
        .osc_en    (osc_en),
        .sel_lock  (sel_lock),
        .sel_card  (sel_card),
        .hsr_flags (hsr_flags),
        .chr_flags (chr_flags),
        .irq_n     (irq_n)
    );

    // Vector: [4] aux_mask, [3] chr_mask, [2:1] event (0 aux, 1 tbe, 2 rbf, 3 card1), [0] expected irq_n
    localparam logic [4:0] VEC [8] = '{
        5'b0_0_00_0, 5'b1_0_00_1, 5'b0_0_01_0, 5'b0_1_01_1,
        5'b1_0_10_0, 5'b0_1_10_1, 5'b1_1_11_0, 5'b1_1_00_1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        hsr_rd = 1'b1; chr_rd = 1'b1;
        cyc(1);
        hsr_rd = 1'b0; chr_rd = 1'b0;
        cyc(1);
    endtask

    task automatic enter_pd();
        pdwn_req = 1'b0;
        cyc(1);
        pdwn_req = 1'b1;
        cyc(3);
    endtask

    task automatic wait_run();
        for (int i = 0; i < 200; i++) begin
            cyc(1);
            if (!sel_lock) break;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 osc_en", osc_en, 1);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 sel_lock", sel_lock, 0);
        chk("R1 hsr_flags", hsr_flags, 0);
        chk("R1 chr_flags", chr_flags, 0);

        // R2 selection while running
        sel_idx = 1'b1; sel_req = 1'b1;
        cyc(1);
        sel_req = 1'b0;
        cyc(1);
        chk("R2 sel while running", sel_card, 1);

        // R8 R9 R11 mask table
        for (int v = 0; v < 8; v++) begin
            aux_mask = VEC[v][4];
            chr_mask = VEC[v][3];
            cyc(1);
            case (VEC[v][2:1])
                2'd0: aux_pin = ~aux_pin;
                2'd1: tbe_evt = 1'b1;
                2'd2: rbf_evt = 1'b1;
                default: card_det[1] = ~card_det[1];
            endcase
            cyc(1);
            tbe_evt = 1'b0; rbf_evt = 1'b0;
            cyc(6);
            case (VEC[v][2:1])
                2'd0: chk("R8 aux flag latched", hsr_flags[2], 1);
                2'd1: chk("R9 tbe flag latched", chr_flags[0], 1);
                2'd2: chk("R9 rbf flag latched", chr_flags[1], 1);
                default: chk("R11 card1 flag latched", hsr_flags[1], 1);
            endcase
            chk("R11 irq vs mask table", irq_n, VEC[v][0]);
            clear_all();
            chk("R10 irq released after reads", irq_n, 1);
        end
        aux_mask = 1'b0; chr_mask = 1'b0;

        // R10 selective clear and set priority
        tbe_evt = 1'b1; aux_pin = ~aux_pin;
        cyc(1);
        tbe_evt = 1'b0;
        cyc(6);
        chr_rd = 1'b1;
        cyc(1);
        chr_rd = 1'b0;
        cyc(1);
        chk("R10 chr_rd clears chr", chr_flags, 0);
        chk("R10 chr_rd keeps aux", hsr_flags[2], 1);
        hsr_rd = 1'b1;
        cyc(1);
        hsr_rd = 1'b0;
        cyc(1);
        chk("R10 hsr_rd clears hsr", hsr_flags, 0);
        rbf_evt = 1'b1; chr_rd = 1'b1;
        cyc(1);
        rbf_evt = 1'b0; chr_rd = 1'b0;
        cyc(1);
        chk("R10 set beats clear", chr_flags, 2'b10);
        clear_all();

        // R2 power-down entry and frozen selection
        enter_pd();
        chk("R2 osc off", osc_en, 0);
        chk("R2 lock on", sel_lock, 1);
        chk("R7 irq quiet in power-down", irq_n, 1);
        sel_idx = 1'b0; sel_req = 1'b1;
        cyc(1);
        sel_req = 1'b0;
        cyc(2);
        chk("R2 sel ignored while locked", sel_card, 1);

        // R4 chip-select reselection, R7 restart delay
        cs_n = 1'b1;
        cyc(6);
        chk("R4 deselect alone keeps down", osc_en, 0);
        cs_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (osc_en) break;
        end
        chk("R4 osc restarts", osc_en, 1);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            if (!irq_n) break;
            cyc(1);
            n++;
        end
        chk("R7 restart delay cycles", n, RESTART_CYC);
        chk("R4 no hsr bits", hsr_flags, 0);
        chk("R4 no chr bits", chr_flags, 0);
        hsr_rd = 1'b1;
        cyc(1);
        hsr_rd = 1'b0;
        cyc(1);
        chk("R4 irq released by read", irq_n, 1);

        // R3 card insertion wake
        enter_pd();
        card_det[0] = 1'b1;
        wait_run();
        chk("R3 card0 flag", hsr_flags[0], 1);
        chk("R3 irq low", irq_n, 0);
        clear_all();

        // R5 auxiliary pin wake
        enter_pd();
        aux_pin = ~aux_pin;
        wait_run();
        chk("R5 aux flag", hsr_flags[2], 1);
        chk("R5 irq low", irq_n, 0);
        clear_all();

        // R6 software clear with chip select low
        enter_pd();
        pdwn_req = 1'b0;
        wait_run();
        chk("R6 woke by software", sel_lock, 0);
        chk("R6 no hsr bits", hsr_flags, 0);
        clear_all();

        // R6 software clear while deselected keeps power-down
        enter_pd();
        cs_n = 1'b1;
        cyc(4);
        pdwn_req = 1'b0;
        cyc(8);
        chk("R6 no wake while deselected", osc_en, 0);
        cs_n = 1'b0;
        wait_run();
        chk("R6 reselect wakes", osc_en, 1);
        clear_all();

        // R8 unmasking a pending auxiliary flag
        aux_mask = 1'b1;
        aux_pin = ~aux_pin;
        cyc(6);
        chk("R8 masked irq high", irq_n, 1);
        chk("R8 flag set", hsr_flags[2], 1);
        aux_mask = 1'b0;
        cyc(1);
        chk("R8 unmask asserts irq", irq_n, 0);
        clear_all();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule